// File: doc/BRIEF.md
# Late-Write Synchronous Static Memory

This block is a single-port synchronous memory whose writes run one clock behind their commands. On a rising edge the block registers a command made of the address, the write request, the per-byte write mask and the select. A write's data word is taken on the following rising edge and kept in a holding register. The array is updated from that register one edge later. Read data appears on the falling edge of the same cycle in which the read was registered, together with an output-enable flag.

A read can hit a write that has not yet reached the array. In that case the block merges the held bytes over the array word, so software always sees the most recent data. Each edge can register a new command while it takes the data for the previous one, so writes stream with no bubbles. A sleep input blocks new commands and keeps the output disabled. A write already in flight still completes, and stored data is kept.

Depth, byte width and bytes per word are parameters. The word width is their product.

Top module: `lw_sram_top`

## Requirements
- R1: A command is registered on a rising edge only when `sel` is 1 and `sleep` is 0. `wrEn`=1 makes it a write and `wrEn`=0 makes it a read.
- R2: The data for a write is the `wdata` value present at the rising edge that follows the write command's edge. The `wdata` present at the command's own edge is not used.
- R3: After a read registered at a rising edge, `rdOe` is 1 and `rdData` holds the word from the falling edge of that same cycle until the next falling edge.
- R4: Bit i of `byteWe` enables byte i, which is `wdata[i*BYTE_W +: BYTE_W]`. Bytes whose bit is 0 keep their stored value, so an all-zero mask leaves the word unchanged.
- R5: A read to an address whose write data has been taken but not yet committed returns the new bytes merged with the stored bytes.
- R6: At a rising edge with `sel`=0, nothing is registered and `rdOe` is 0 for that cycle.
- R7: At a rising edge with `sleep`=1, the command is ignored and `rdOe` is 0 for that cycle. A write registered before the sleep still takes its data and completes, and stored contents are kept across sleep.
- R8: Writes on consecutive edges each complete with their own data and mask, with no idle cycle between them.
- R9: While `rstN` is 0, `rdOe` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands on rising edge, read output on falling edge |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| sel | input | 1 | Synchronous select, active high |
| wrEn | input | 1 | 1 = write command, 0 = read command |
| byteWe | input | BYTES | Per-byte write enables for a write command |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTES*BYTE_W | Write data, one rising edge after its command |
| sleep | input | 1 | Sleep request, active high |
| rdData | output | BYTES*BYTE_W | Read data, updated on the falling edge |
| rdOe | output | 1 | Output enable; 0 models a tri-stated output |

## Verification
The bench builds the block with 16 words of two 9-bit bytes. With so few addresses, random traffic often reads a word while a write to it is still in the holding register, and often issues back-to-back writes to the same word. Those are the cases where the bypass merge and the pipeline ordering can fail. Using two bytes keeps every mask pattern, including the all-zero and partial masks, frequent in random traffic.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef struct packed {
    logic takeRd;   // register a read at this edge
    logic takeWr;   // register a write at this edge
    logic captData; // write data for the pending command arrives at this edge
    logic holdLive; // holding register carries uncommitted data
    logic rdLive;   // a read was registered at the last rising edge
  } lwStrobe_t;
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sel,
  input  logic      wrEn,
  input  logic      sleep,
  output lwStrobe_t strobes
);
  logic pendValid, holdValid, rdActive;
  logic cmdOk;

  assign cmdOk = sel && !sleep;

  always_comb begin
    strobes.takeRd   = cmdOk && !wrEn;
    strobes.takeWr   = cmdOk && wrEn;
    strobes.captData = pendValid;
    strobes.holdLive = holdValid;
    strobes.rdLive   = rdActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      holdValid <= 1'b0;
      rdActive  <= 1'b0;
    end else begin
      pendValid <= strobes.takeWr;
      holdValid <= pendValid;
      rdActive  <= strobes.takeRd;
    end
  end

  // R7
  sleep_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> !pendValid && !rdActive);
  // R6
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> !rdActive && !pendValid);
  // R8
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendValid && strobes.takeWr |=> pendValid && holdValid);
  // R7
  pending_finishes_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |=> holdValid);
endmodule

// File: rtl/lw_sram_dp.sv
module lw_sram_dp
  import lw_sram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lwStrobe_t         strobes,
  input  logic [BYTES-1:0]  byteWe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdData,
  output logic              rdOe
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pendAddr, holdAddr, rdAddr;
  logic [BYTES-1:0]  pendMask, holdMask;
  logic [WORD_W-1:0] holdData, arrWord, merged;
  logic              holdHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendMask <= '0;
      holdAddr <= '0;
      holdMask <= '0;
      holdData <= '0;
      rdAddr   <= '0;
    end else begin
      if (strobes.takeWr) begin
        pendAddr <= addr;
        pendMask <= byteWe;
      end
      if (strobes.takeRd) rdAddr <= addr;
      if (strobes.captData) begin
        holdAddr <= pendAddr;
        holdMask <= pendMask;
        holdData <= wdata;
      end
    end
  end

  // Array update from the holding register, one edge after data capture
  always_ff @(posedge clk) begin
    if (strobes.holdLive) begin
      for (int b = 0; b < BYTES; b++) begin
        if (holdMask[b]) mem[holdAddr][b*BYTE_W +: BYTE_W] <= holdData[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign arrWord = mem[rdAddr];
  assign holdHit = strobes.holdLive && (holdAddr == rdAddr);

  for (genvar g = 0; g < BYTES; g++) begin : g_merge
    assign merged[g*BYTE_W +: BYTE_W] = (holdHit && holdMask[g]) ?
      holdData[g*BYTE_W +: BYTE_W] : arrWord[g*BYTE_W +: BYTE_W];
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOe   <= 1'b0;
      rdData <= '0;
    end else begin
      rdOe <= strobes.rdLive;
      if (strobes.rdLive) rdData <= merged;
    end
  end

  // R3
  oe_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdOe == strobes.rdLive);
  // R4
  masked_bytes_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdLive && (holdMask == '0) |=> mem[$past(holdAddr)] == $past(mem[holdAddr]));
  // R9
  always_comb begin
    reset_quiet_chk: assert (rstN || !rdOe);
  end
endmodule

// File: rtl/lw_sram_top.sv
module lw_sram_top
  import lw_sram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [BYTES-1:0]  byteWe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              sleep,
  output logic [WORD_W-1:0] rdData,
  output logic              rdOe
);
  lwStrobe_t strobes;

  lw_sram_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .sleep(sleep), .strobes(strobes)
  );

  lw_sram_dp #(.DEPTH(DEPTH), .BYTES(BYTES), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteWe(byteWe), .addr(addr),
    .wdata(wdata), .rdData(rdData), .rdOe(rdOe)
  );
endmodule

// File: tb/lw_sram_top_tb_top.sv
module lw_sram_top_tb_top;
  localparam int DEPTH = 16, BYTES = 2, BYTE_W = 9;
  localparam int AW = $clog2(DEPTH), WW = BYTES * BYTE_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic sel = 1'b0, wrEn = 1'b0, sleep = 1'b0;
  logic [BYTES-1:0] byteWe = '0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdData;
  logic rdOe;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  logic [WW-1:0] refMem [DEPTH];
  bit refPend = 1'b0;
  logic [AW-1:0] refPendA;
  logic [BYTES-1:0] refPendM;

  always #4 clk = ~clk;

  lw_sram_top #(.DEPTH(DEPTH), .BYTES(BYTES), .BYTE_W(BYTE_W)) dut_i (
    .clk(clk), .rstN(rstN), .sel(sel), .wrEn(wrEn), .byteWe(byteWe), .addr(addr),
    .wdata(wdata), .sleep(sleep), .rdData(rdData), .rdOe(rdOe)
  );

  function automatic logic [WW-1:0] mergeBytes(logic [WW-1:0] oldW, logic [WW-1:0] newW,
                                               logic [BYTES-1:0] m);
    logic [WW-1:0] r = oldW;
    for (int b = 0; b < BYTES; b++) if (m[b]) r[b*BYTE_W +: BYTE_W] = newW[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive, rising edge, update model, check after the falling edge.
  // dat is the write data offered at this edge (used by a write registered one edge earlier).
  task automatic step(bit s, bit w, logic [BYTES-1:0] m, logic [AW-1:0] a,
                      logic [WW-1:0] dat, bit slp, string tag);
    bit isRd;
    logic [WW-1:0] exp;
    sel = s; wrEn = w; byteWe = m; addr = a; wdata = dat; sleep = slp;
    @(posedge clk);
    if (refPend) refMem[refPendA] = mergeBytes(refMem[refPendA], dat, refPendM);  // R2
    refPend = s && !slp && w;
    refPendA = a; refPendM = m;
    isRd = s && !slp && !w;
    exp = refMem[a];
    #6;
    if (isRd) begin
      chk(rdOe === 1'b1, {tag, " R3 oe"}, {{(WW-1){1'b0}}, rdOe}, 1);
      chk(rdData === exp, {tag, " R3 data"}, rdData, exp);
    end else begin
      chk(rdOe === 1'b0, {tag, " R6/R7 oe off"}, {{(WW-1){1'b0}}, rdOe}, 0);
    end
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    #10;
    chk(rdOe === 1'b0, "R9 reset oe", {{(WW-1){1'b0}}, rdOe}, 0);
    #4 rstN = 1'b1;
    #2;
    // R8: back-to-back full writes to every word
    for (int i = 0; i < DEPTH; i++) step(1, 1, '1, AW'(i), WW'($urandom), 0, "R8 init");
    step(0, 0, '0, '0, WW'($urandom), 0, "R6 idle");
    for (int i = 0; i < DEPTH; i++) step(1, 0, '0, AW'(i), WW'($urandom), 0, "R8 readback");
    // R5: partial write then immediate read of same word
    step(1, 1, 2'b01, 4'd3, 18'h3ffff, 0, "R2 junk");
    step(1, 0, '0, 4'd3, 18'h12345, 0, "R5 hit low");
    step(1, 1, 2'b10, 4'd3, 18'h00000, 0, "R4 hi");
    step(1, 0, '0, 4'd3, 18'h2aaaa, 0, "R5 hit high");
    // R4: zero mask changes nothing
    step(1, 1, 2'b00, 4'd5, '0, 0, "R4 zero");
    step(1, 0, '0, 4'd5, 18'h3ffff, 0, "R4 zero read");
    // R7: write then sleep; data still taken, commands ignored, contents kept
    step(1, 1, '1, 4'd7, '0, 0, "R7 pre");
    step(1, 0, '0, 4'd7, 18'h0beef, 1, "R7 sleep data");
    step(1, 1, '1, 4'd7, 18'h11111, 1, "R7 sleep wr");
    step(1, 0, '0, 4'd7, 18'h22222, 1, "R7 sleep rd");
    step(1, 0, '0, 4'd7, 18'h33333, 0, "R7 wake read");
    // R6: deselected write ignored
    step(0, 1, '1, 4'd7, '0, 0, "R6 desel wr");
    step(1, 0, '0, 4'd7, 18'h1, 0, "R6 check");
    // Random traffic: R1 R3 R4 R5 R8
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 10) != 0, $urandom % 2, BYTES'($urandom), AW'($urandom),
           WW'($urandom), ($urandom % 10) == 0, "R1 rand");
    end
    step(0, 0, '0, '0, WW'($urandom), 0, "flush");
    for (int i = 0; i < DEPTH; i++) step(1, 0, '0, AW'(i), WW'($urandom), 0, "R1 final");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule